// File: doc/BRIEF.md
# Power-up reset time-out sequencer

This block decides when a microcontroller core may leave reset after power is applied or after it wakes from sleep. A power-on pulse starts a power-up delay counted on a slow internal RC clock. When that delay is over, a second delay of a fixed number of main-oscillator cycles gives a crystal or resonator time to settle. Only then does the core reset output drop. The power-up delay can be turned off by a configuration bit. The oscillator delay is skipped when the clock source is an RC or external clock.

A wake-from-sleep event repeats only the oscillator delay. An already filtered, active-low master clear input holds the core in reset whenever it is low. The timers keep running while master clear is low. If master clear stays low until both delays are over, raising it releases the core almost at once. A done output shows that the sequence is complete, whatever master clear is doing. This lets a test see that the delays have expired while the core is still held.

Top module: `reset_timeout_seq`

## Requirements
- R1: While the power-on input is high, and in the cycle after the oscillator-domain copy of it is seen high, `core_rst` is 1 and `seq_done` is 0.
- R2: With `pwrt_en`=1, `core_rst` stays 1 for `PWRT_TICKS` rising edges of `clk_rc` after the power-on pulse ends, plus synchronizer latency. A wake does not restart this delay.
- R3: With `pwrt_en`=0, the power-up delay takes a single `clk_rc` edge.
- R4: In the crystal modes (`osc_mode` 2'b00, 2'b01, 2'b10), `OST_CYCLES` cycles of `clk_osc` follow the power-up delay before release.
- R5: In RC mode (`osc_mode` 2'b11), the oscillator delay is skipped and release follows the power-up delay.
- R6: A one-cycle `wake_in` pulse while `seq_done`=1 in a crystal mode sets `core_rst` to 1 and clears `seq_done` on the next `clk_osc` cycle. It then releases after `OST_CYCLES` cycles.
- R7: `wake_in` in RC mode has no effect: `core_rst` stays 0 and `seq_done` stays 1.
- R8: While the synchronized `mclr_n` is 0, `core_rst` is 1. After `mclr_n` rises, `core_rst` falls within 4 `clk_osc` cycles if the sequence is complete.
- R9: If `mclr_n` is held low through both delays, `seq_done` becomes 1 while `core_rst` stays 1. Raising `mclr_n` then releases reset without any further delay. `core_rst` never falls unless `seq_done` is 1.
- R10: Once `seq_done` is 1 it stays 1 until a new power-on pulse or a crystal-mode wake, including while `mclr_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Main oscillator clock |
| clk_rc | input | 1 | Slow internal RC clock for the power-up delay |
| por_in | input | 1 | Asynchronous power-on pulse, active high; also resets the block |
| wake_in | input | 1 | Wake-from-sleep pulse, synchronous to clk_osc |
| mclr_n | input | 1 | Filtered asynchronous master clear, active low |
| osc_mode | input | 2 | 00 LP, 01 XT, 10 HS, 11 RC |
| pwrt_en | input | 1 | 1 enables the power-up delay |
| core_rst | output | 1 | Core reset, active high, registered in clk_osc |
| seq_done | output | 1 | Both delays have elapsed (test visibility) |

## Verification
The hardest state to reach is a completed sequence whose release is still blocked. In that state `seq_done` is 1 and `core_rst` is 1 only because master clear is low. The bench reaches it by pulling `mclr_n` low before the power-on pulse and keeping it low well past the expected delay. It then checks both outputs, raises `mclr_n`, and expects a release within a few cycles. A second case of the same kind is the wake from sleep. The bench lets a crystal-mode sequence finish and then pulses `wake_in`. It checks that only the short oscillator delay is replayed, and not the power-up delay.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    typedef enum logic [1:0] {
        OSC_LP = 2'b00,
        OSC_XT = 2'b01,
        OSC_HS = 2'b10,
        OSC_RC = 2'b11
    } osc_mode_e;

    typedef enum logic [1:0] {
        SEQ_PWRT = 2'b00,
        SEQ_OST  = 2'b01,
        SEQ_RUN  = 2'b10
    } seq_state_e;

    // crystal-type sources need a settling count; RC/external does not
    function automatic logic needs_ost(input osc_mode_e m);
        return m != OSC_RC;
    endfunction

endpackage

// File: rtl/rsq_sync2.sv
module rsq_sync2 (
    input  logic clk,
    input  logic d,
    output logic q
);
    logic meta;

    always_ff @(posedge clk) begin
        meta <= d;
        q    <= meta;
    end
endmodule

// File: rtl/rsq_pwrt_timer.sv
module rsq_pwrt_timer #(
    parameter int unsigned TICKS = 2304
) (
    input  logic clk_rc,
    input  logic rst,
    input  logic enable,
    output logic done
);
    localparam int unsigned W = $clog2(TICKS + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk_rc) begin
        if (rst) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (!done) begin
            if (!enable || cnt == W'(TICKS - 1)) begin
                done <= 1'b1;
            end else begin
                cnt <= cnt + W'(1);
            end
        end
    end
endmodule

// File: rtl/rsq_ost_seq.sv
module rsq_ost_seq
    import rsq_pkg::*;
#(
    parameter int unsigned CYCLES = 1024
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwrt_done,
    input  logic       wake,
    input  osc_mode_e  mode,
    input  logic       mclr_ok,
    output seq_state_e state,
    output logic       core_rst,
    output logic       seq_done
);
    localparam int unsigned CW = $clog2(CYCLES + 1);

    seq_state_e    state_n;
    logic [CW-1:0] cnt, cnt_n;
    logic          armed, armed_n;

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        armed_n = armed;
        case (state)
            SEQ_PWRT: begin
                // a done flag left over from before this power-on is not trusted
                if (!pwrt_done) armed_n = 1'b1;
                if (armed && pwrt_done) begin
                    if (needs_ost(mode)) begin
                        state_n = SEQ_OST;
                        cnt_n   = '0;
                    end else begin
                        state_n = SEQ_RUN;
                    end
                end
            end
            SEQ_OST: begin
                if (cnt == CW'(CYCLES - 1)) state_n = SEQ_RUN;
                else                        cnt_n   = cnt + CW'(1);
            end
            SEQ_RUN: begin
                if (wake && needs_ost(mode)) begin
                    state_n = SEQ_OST;
                    cnt_n   = '0;
                end
            end
            default: state_n = SEQ_PWRT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SEQ_PWRT;
            cnt      <= '0;
            armed    <= 1'b0;
            core_rst <= 1'b1;
        end else begin
            state    <= state_n;
            cnt      <= cnt_n;
            armed    <= armed_n;
            core_rst <= (state_n != SEQ_RUN) || !mclr_ok;
        end
    end

    assign seq_done = (state == SEQ_RUN);
endmodule

// File: rtl/reset_timeout_seq.sv
module reset_timeout_seq
    import rsq_pkg::*;
#(
    parameter int unsigned PWRT_TICKS = 2304,
    parameter int unsigned OST_CYCLES = 1024
) (
    input  logic       clk_osc,
    input  logic       clk_rc,
    input  logic       por_in,
    input  logic       wake_in,
    input  logic       mclr_n,
    input  logic [1:0] osc_mode,
    input  logic       pwrt_en,
    output logic       core_rst,
    output logic       seq_done
);
    logic       por_rc, por_osc, mclr_osc;
    logic       pwrt_done_rc, pwrt_done_osc;
    seq_state_e seq_state;

    rsq_sync2 u_por_rc   (.clk(clk_rc),  .d(por_in),       .q(por_rc));
    rsq_sync2 u_por_osc  (.clk(clk_osc), .d(por_in),       .q(por_osc));
    rsq_sync2 u_mclr_osc (.clk(clk_osc), .d(mclr_n),       .q(mclr_osc));
    rsq_sync2 u_done_osc (.clk(clk_osc), .d(pwrt_done_rc), .q(pwrt_done_osc));

    rsq_pwrt_timer #(.TICKS(PWRT_TICKS)) u_pwrt (
        .clk_rc (clk_rc),
        .rst    (por_rc),
        .enable (pwrt_en),
        .done   (pwrt_done_rc)
    );

    rsq_ost_seq #(.CYCLES(OST_CYCLES)) u_ost (
        .clk       (clk_osc),
        .rst       (por_osc),
        .pwrt_done (pwrt_done_osc),
        .wake      (wake_in),
        .mode      (osc_mode_e'(osc_mode)),
        .mclr_ok   (mclr_osc),
        .state     (seq_state),
        .core_rst  (core_rst),
        .seq_done  (seq_done)
    );
endmodule

// File: rtl/rsq_checker.sv
module rsq_checker
    import rsq_pkg::*;
#(
    parameter int unsigned OST_CYCLES = 1024
) (
    input logic       clk_osc,
    input logic       por_s,
    input logic       mclr_s,
    input seq_state_e state,
    input logic [1:0] mode,
    input logic       wake,
    input logic       core_rst,
    input logic       seq_done
);
    logic seen_por = 1'b0;
    int   ost_len  = 0;
    logic crystal;

    assign crystal = (mode != 2'b11);

    always_ff @(posedge clk_osc) begin
        if (por_s) seen_por <= 1'b1;
        if (state == SEQ_OST) ost_len <= ost_len + 1;
        else                  ost_len <= 0;
    end

    assert_rst_after_por_R1: assert property (@(posedge clk_osc) disable iff (!seen_por)
        por_s |=> (core_rst && !seq_done));

    assert_ost_length_R4: assert property (@(posedge clk_osc) disable iff (!seen_por || por_s)
        ($fell(state == SEQ_OST) && state == SEQ_RUN) |-> (ost_len == OST_CYCLES));

    assert_rc_no_ost_R5: assert property (@(posedge clk_osc) disable iff (!seen_por || por_s)
        ($past(mode) == 2'b11 && $past(state) != SEQ_OST) |-> (state != SEQ_OST));

    assert_wake_reasserts_R6: assert property (@(posedge clk_osc) disable iff (!seen_por || por_s)
        (seq_done && wake && crystal) |=> (core_rst && state == SEQ_OST));

    assert_mclr_holds_R8: assert property (@(posedge clk_osc) disable iff (!seen_por)
        !mclr_s |=> core_rst);

    assert_release_needs_done_R9: assert property (@(posedge clk_osc) disable iff (!seen_por || por_s)
        $fell(core_rst) |-> seq_done);

    assert_run_sticky_R10: assert property (@(posedge clk_osc) disable iff (!seen_por || por_s)
        (seq_done && !(wake && crystal)) |=> seq_done);
endmodule

bind reset_timeout_seq rsq_checker #(.OST_CYCLES(OST_CYCLES)) u_chk (
    .clk_osc  (clk_osc),
    .por_s    (por_osc),
    .mclr_s   (mclr_osc),
    .state    (seq_state),
    .mode     (osc_mode),
    .wake     (wake_in),
    .core_rst (core_rst),
    .seq_done (seq_done)
);

// File: tb/reset_timeout_seq_tb.sv
module reset_timeout_seq_tb;
    localparam int PWRT_T = 20;
    localparam int OST_C  = 64;
    localparam int RC_NS  = 80;
    localparam int OSC_NS = 10;
    localparam int SLACK  = 450;

    logic clk_osc = 1'b0, clk_rc = 1'b0;
    logic por_in = 1'b0, wake_in = 1'b0, mclr_n = 1'b1, pwrt_en = 1'b1;
    logic [1:0] osc_mode = 2'b01;
    logic core_rst, seq_done;

    typedef struct {
        longint t0;
        longint lo;
        longint hi;
        string  tag;
    } exp_t;

    exp_t   sb_q[$];
    int     n_chk = 0, n_err = 0;
    bit     mon_en = 1'b0;
    bit     ended = 1'b0;

    reset_timeout_seq #(.PWRT_TICKS(PWRT_T), .OST_CYCLES(OST_C)) u_dut (
        .clk_osc(clk_osc), .clk_rc(clk_rc), .por_in(por_in), .wake_in(wake_in),
        .mclr_n(mclr_n), .osc_mode(osc_mode), .pwrt_en(pwrt_en),
        .core_rst(core_rst), .seq_done(seq_done)
    );

    always #5 clk_osc = ~clk_osc;
    initial begin
        #17;
        forever begin clk_rc = ~clk_rc; #40; end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    task automatic push_exp(input longint lo, input longint hi, input string tag);
        exp_t e;
        e.t0 = $time; e.lo = lo; e.hi = hi; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic drain();
        while (sb_q.size() != 0) @(negedge clk_osc);
        #100;
    endtask

    // monitor: every falling core_rst must match a queued expectation
    always @(negedge core_rst) begin
        if (mon_en) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R7 unexpected release", 0, 1);
            end else begin
                exp_t e;
                longint el;
                e  = sb_q.pop_front();
                el = $time - e.t0;
                chk(el >= e.lo && el <= e.hi, e.tag, el, e.lo);
            end
        end
    end

    task automatic power_on(input logic [1:0] m, input logic en);
        @(negedge clk_osc);
        osc_mode = m; pwrt_en = en; por_in = 1'b1;
        #300;
        chk(core_rst == 1'b1 && seq_done == 1'b0, "R1 reset during power-on",
            {core_rst, seq_done}, 2'b10);
        #660;
        @(negedge clk_osc);
        por_in = 1'b0;
    endtask

    function automatic longint nominal(input logic [1:0] m, input logic en);
        longint v;
        v = en ? longint'(PWRT_T * RC_NS) : longint'(RC_NS);
        if (m != 2'b11) v += OST_C * OSC_NS;
        return v;
    endfunction

    initial begin
        #1_500_000;
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        longint nom;
        #50;
        mon_en = 1'b1;

        // R2 R4: XT mode, power-up delay on
        power_on(2'b01, 1'b1);
        nom = nominal(2'b01, 1'b1);
        push_exp(nom, nom + SLACK, "R4 XT full sequence");
        #800;
        chk(core_rst == 1'b1, "R2 held during power-up delay", core_rst, 1);
        drain();
        chk(seq_done == 1'b1, "R10 done after release", seq_done, 1);

        // R6: crystal-mode wake replays only the oscillator delay
        @(negedge clk_osc);
        wake_in = 1'b1;
        push_exp(OST_C * OSC_NS, OST_C * OSC_NS + 30, "R6 wake replays oscillator delay");
        @(negedge clk_osc);
        wake_in = 1'b0;
        chk(core_rst == 1'b1 && seq_done == 1'b0, "R6 wake reasserts reset",
            {core_rst, seq_done}, 2'b10);
        drain();

        // R5: RC mode skips the oscillator delay
        power_on(2'b11, 1'b1);
        nom = nominal(2'b11, 1'b1);
        push_exp(nom, nom + SLACK, "R5 RC mode skips oscillator delay");
        drain();

        // R7: wake ignored in RC mode
        @(negedge clk_osc);
        wake_in = 1'b1;
        @(negedge clk_osc);
        wake_in = 1'b0;
        repeat (100) @(negedge clk_osc);
        chk(core_rst == 1'b0 && seq_done == 1'b1, "R7 RC wake ignored",
            {core_rst, seq_done}, 2'b01);

        // R3: power-up delay disabled, HS mode
        power_on(2'b10, 1'b0);
        nom = nominal(2'b10, 1'b0);
        push_exp(nom, nom + SLACK, "R3 disabled power-up delay HS");
        drain();

        // R3 R5: both stages skipped
        power_on(2'b11, 1'b0);
        nom = nominal(2'b11, 1'b0);
        push_exp(nom, nom + SLACK, "R3 disabled power-up delay RC");
        drain();

        // R4: LP mode full sequence
        power_on(2'b00, 1'b1);
        nom = nominal(2'b00, 1'b1);
        push_exp(nom, nom + SLACK, "R4 LP full sequence");
        drain();

        // R8 R10: master clear low after completion
        @(negedge clk_osc);
        mclr_n = 1'b0;
        repeat (5) @(negedge clk_osc);
        chk(core_rst == 1'b1, "R8 master clear forces reset", core_rst, 1);
        chk(seq_done == 1'b1, "R10 done kept while master clear low", seq_done, 1);
        @(negedge clk_osc);
        mclr_n = 1'b1;
        push_exp(0, 4 * OSC_NS, "R8 release after master clear rises");
        drain();

        // R9: master clear held through all delays
        mclr_n = 1'b0;
        power_on(2'b01, 1'b1);
        nom = nominal(2'b01, 1'b1);
        #(nom + 600);
        chk(seq_done == 1'b1, "R9 delays expired under master clear", seq_done, 1);
        chk(core_rst == 1'b1, "R9 reset held by master clear", core_rst, 1);
        @(negedge clk_osc);
        mclr_n = 1'b1;
        push_exp(0, 4 * OSC_NS, "R9 immediate release");
        drain();
        chk(sb_q.size() == 0, "R9 scoreboard drained", sb_q.size(), 0);

        finish_run();
    end
endmodule